// File: doc/BRIEF.md
# TDM Frame Phase Aligner

This block keeps a time-division-multiplexed frame timebase in step with an external 8 kHz frame reference, which gives one frame every 125 µs. It runs on the bit-clock reference. Each clock advances a combined position made of a bit index and a slot index. A slot holds 8 bits. A rate select sets how many slots a frame holds. The block reports the current slot and bit, a one-clock internal frame pulse, a locked flag and a loss-of-sync flag.

When the reference edge is absent or misplaced at two internal frame boundaries in a row, the block declares loss of sync. It then re-aligns in one of two ways:
- In the jump alignment mode, it reloads the counters at once from the next reference edge.
- In the walk alignment mode, it moves the internal frame by one bit-clock per reference edge, toward the nearer side, until the two edges coincide.

In timing-master mode the reference is not used and the counters run freely. A new mode or rate is taken only at an internal frame boundary.

Top module: `tdm_frame_aligner`

## Requirements
- R1: The position advances by one each clock. The bit index runs 0..7 inside a slot. After the last bit of the last slot the position returns to slot 0, bit 0. `frame_pulse` is high exactly while the position is slot 0, bit 0.
- R2: `rate_sel` sets the frame size: 0 gives 32 slots (256 clocks), 1 gives 64 slots (512 clocks), and 2 or 3 give 128 slots (1024 clocks).
- R3: `rate_sel` and `mode_sel` are sampled only in the clock where the position is slot 0, bit 0. They govern the timebase from the following clock onward.
- R4: `sync_lost` rises after two consecutive frame boundaries with no coinciding `frame_ref`. One such boundary alone leaves it low. A `frame_ref` that coincides with a boundary clears it.
- R5: `locked` rises after four consecutive boundaries with a coinciding `frame_ref`. It falls in the same clock that `sync_lost` rises. One missed boundary does not clear it.
- R6: Jump mode (`mode_sel`=0). While `sync_lost` is high, a `frame_ref` at position p≠0 makes the next position slot 0, bit 1, and clears `sync_lost`.
- R7: Walk mode (`mode_sel`=1). While `sync_lost` is high, a `frame_ref` at position p≠0 with frame length L does one of two things:
  - If p < L/2, the position holds for one clock.
  - Otherwise the position advances by two, modulo L.
- R8: While `sync_lost` is low, a `frame_ref` away from the boundary leaves the position sequence unchanged.
- R9: Master mode (`mode_sel`=2 or 3). `frame_ref` is ignored, the position free-runs, and `locked` and `sync_lost` are held low.
- R10: After reset the position is slot 0, bit 0, `locked` is low and `sync_lost` is high. The active configuration is jump mode with 128 slots until the first boundary sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-clock reference |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_ref | input | 1 | One-clock pulse marking the reference frame start |
| mode_sel | input | 2 | 0 jump, 1 walk, 2/3 master |
| rate_sel | input | 2 | 0: 32 slots, 1: 64 slots, 2/3: 128 slots |
| slot_idx | output | 7 | Current slot index |
| bit_idx | output | 3 | Current bit index within the slot |
| frame_pulse | output | 1 | High at slot 0, bit 0 |
| locked | output | 1 | Timebase phase-locked to the reference |
| sync_lost | output | 1 | Reference edge judged missing or misplaced |

## Verification
The hardest case to reach is a walk step near the frame wrap, where the rule must pick a direction:
- One variant is a reference edge at exactly half the frame.
- The other is an edge on the last positions of the frame, where advancing by two jumps over the boundary.

Both need sync to be lost first. The bench therefore first brings the timebase into alignment. It then moves the reference phase to a chosen offset and lets two misplaced frames go by, so that the following reference edge lands at the intended position. Random phase jumps, dropped edges and mode changes then drive the block through many re-alignments. A cycle-level model computed in the bench checks every cycle of this.

// File: rtl/tdmfa_pkg.sv
`timescale 1ns/1ps
package tdmfa_pkg;

  typedef enum logic [1:0] {
    MODE_SNAP   = 2'd0,
    MODE_SLIDE  = 2'd1,
    MODE_MASTER = 2'd2
  } align_mode_e;

  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_HOLD = 2'd1,
    STEP_SKIP = 2'd2,
    STEP_SNAP = 2'd3
  } step_e;

  function automatic align_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'd0:    return MODE_SNAP;
      2'd1:    return MODE_SLIDE;
      default: return MODE_MASTER;
    endcase
  endfunction

endpackage

// File: rtl/tdmfa_timebase.sv
`timescale 1ns/1ps
module tdmfa_timebase
  import tdmfa_pkg::*;
#(
  parameter int BITS_PER_SLOT = 8,
  parameter int MAX_SLOTS     = 128,
  localparam int POS_W        = $clog2(BITS_PER_SLOT * MAX_SLOTS),
  localparam int LEN_W        = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             step_i,
  input  logic [1:0]        mode_sel_i,
  input  logic [1:0]        rate_sel_i,
  output logic [POS_W-1:0]  pos_o,
  output logic [LEN_W-1:0]  len_o,
  output align_mode_e       mode_o,
  output logic              boundary_o
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(BITS_PER_SLOT * MAX_SLOTS);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [1:0]       rate_q;
  align_mode_e      mode_q;
  logic             cfg_en;
  logic [LEN_W-1:0] len, last, pos_x;

  // frame length from the active rate
  always_comb begin
    case (rate_q)
      2'd0:    len = FULL_LEN >> 2;
      2'd1:    len = FULL_LEN >> 1;
      default: len = FULL_LEN;
    endcase
  end

  assign pos_x      = {1'b0, pos_q};
  assign last       = len - LEN_W'(1);
  assign boundary_o = (pos_q == '0);
  assign cfg_en     = boundary_o;

  // next position
  always_comb begin
    case (step_i)
      STEP_HOLD: pos_d = pos_q;
      STEP_SNAP: pos_d = POS_W'(1);
      STEP_SKIP: begin
        if (pos_x == last)                      pos_d = POS_W'(1);
        else if (pos_x + LEN_W'(1) == last)     pos_d = '0;
        else                                    pos_d = POS_W'(pos_x + LEN_W'(2));
      end
      default:   pos_d = (pos_x == last) ? '0 : POS_W'(pos_x + LEN_W'(1));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      rate_q <= 2'd2;
      mode_q <= MODE_SNAP;
    end else begin
      pos_q <= pos_d;
      if (cfg_en) begin
        rate_q <= rate_sel_i;
        mode_q <= decode_mode(mode_sel_i);
      end
    end
  end

  assign pos_o  = pos_q;
  assign len_o  = len;
  assign mode_o = mode_q;

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_x < len);
  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_RUN && pos_x == last) |=> (pos_q == '0));
  // R6
  snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_SNAP) |=> (pos_q == POS_W'(1)));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_HOLD) |=> $stable(pos_q));

endmodule

// File: rtl/tdmfa_phase_ctl.sv
`timescale 1ns/1ps
module tdmfa_phase_ctl
  import tdmfa_pkg::*;
#(
  parameter int POS_W = 10,
  localparam int LEN_W = POS_W + 1
) (
  input  logic              frame_ref_i,
  input  logic              sync_lost_i,
  input  align_mode_e       mode_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [LEN_W-1:0]  len_i,
  output step_e             step_o
);

  logic misplaced;

  assign misplaced = frame_ref_i && sync_lost_i && (pos_i != '0) &&
                     (mode_i != MODE_MASTER);

  always_comb begin
    step_o = STEP_RUN;
    if (misplaced) begin
      if (mode_i == MODE_SNAP)
        step_o = STEP_SNAP;
      else if ({1'b0, pos_i} < (len_i >> 1))
        step_o = STEP_HOLD;   // internal frame ahead: retard one clock
      else
        step_o = STEP_SKIP;   // internal frame behind: advance one clock
    end
  end

endmodule

// File: rtl/tdmfa_sync_mon.sv
`timescale 1ns/1ps
module tdmfa_sync_mon
  import tdmfa_pkg::*;
#(
  parameter int MISS_LIMIT = 2,
  parameter int LOCK_LIMIT = 4,
  localparam int MW = $clog2(MISS_LIMIT + 1),
  localparam int GW = $clog2(LOCK_LIMIT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary_i,
  input  logic        frame_ref_i,
  input  step_e       step_i,
  input  align_mode_e mode_i,
  output logic        locked_o,
  output logic        sync_lost_o
);

  logic [MW-1:0] miss_q, miss_d;
  logic [GW-1:0] good_q, good_d;
  logic          lost_q, lost_d;
  logic          lock_q, lock_d;

  always_comb begin
    miss_d = miss_q;
    good_d = good_q;
    lost_d = lost_q;
    lock_d = lock_q;
    if (mode_i == MODE_MASTER) begin
      miss_d = '0;
      good_d = '0;
      lost_d = 1'b0;
      lock_d = 1'b0;
    end else if (boundary_i) begin
      if (frame_ref_i) begin
        miss_d = '0;
        lost_d = 1'b0;
        if (good_q != GW'(LOCK_LIMIT)) good_d = good_q + GW'(1);
        if (int'(good_q) + 1 >= LOCK_LIMIT) lock_d = 1'b1;
      end else begin
        good_d = '0;
        if (miss_q != MW'(MISS_LIMIT)) miss_d = miss_q + MW'(1);
        if (int'(miss_q) + 1 >= MISS_LIMIT) begin
          lost_d = 1'b1;
          lock_d = 1'b0;
        end
      end
    end else if (step_i == STEP_SNAP) begin
      miss_d = '0;
      good_d = '0;
      lost_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= '0;
      good_q <= '0;
      lost_q <= 1'b1;
      lock_q <= 1'b0;
    end else begin
      miss_q <= miss_d;
      good_q <= good_d;
      lost_q <= lost_d;
      lock_q <= lock_d;
    end
  end

  assign locked_o    = lock_q;
  assign sync_lost_o = lost_q;

  // R5
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> !lock_q);
  // R4
  lost_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(boundary_i && !frame_ref_i));
  // R9
  master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_MASTER && $past(mode_i) == MODE_MASTER) |-> (!lock_q && !lost_q));

endmodule

// File: rtl/tdm_frame_aligner.sv
`timescale 1ns/1ps
module tdm_frame_aligner
  import tdmfa_pkg::*;
#(
  parameter int BITS_PER_SLOT = 8,
  parameter int MAX_SLOTS     = 128,
  parameter int MISS_LIMIT    = 2,
  parameter int LOCK_LIMIT    = 4,
  localparam int BIT_W  = $clog2(BITS_PER_SLOT),
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int POS_W  = BIT_W + SLOT_W,
  localparam int LEN_W  = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ref,
  input  logic [1:0]        mode_sel,
  input  logic [1:0]        rate_sel,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              frame_pulse,
  output logic              locked,
  output logic              sync_lost
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [POS_W-1:0] pos;
  logic [LEN_W-1:0] len;
  align_mode_e      mode_act;
  logic             boundary;
  step_e            step;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tdmfa_timebase #(
    .BITS_PER_SLOT (BITS_PER_SLOT),
    .MAX_SLOTS     (MAX_SLOTS)
  ) u_timebase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .step_i     (step),
    .mode_sel_i (mode_sel),
    .rate_sel_i (rate_sel),
    .pos_o      (pos),
    .len_o      (len),
    .mode_o     (mode_act),
    .boundary_o (boundary)
  );

  tdmfa_phase_ctl #(
    .POS_W (POS_W)
  ) u_phase_ctl (
    .frame_ref_i (frame_ref),
    .sync_lost_i (sync_lost),
    .mode_i      (mode_act),
    .pos_i       (pos),
    .len_i       (len),
    .step_o      (step)
  );

  tdmfa_sync_mon #(
    .MISS_LIMIT (MISS_LIMIT),
    .LOCK_LIMIT (LOCK_LIMIT)
  ) u_sync_mon (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .boundary_i  (boundary),
    .frame_ref_i (frame_ref),
    .step_i      (step),
    .mode_i      (mode_act),
    .locked_o    (locked),
    .sync_lost_o (sync_lost)
  );

  assign slot_idx    = pos[POS_W-1:BIT_W];
  assign bit_idx     = pos[BIT_W-1:0];
  assign frame_pulse = boundary;

endmodule

// File: tb/tdm_frame_aligner_bench.sv
`timescale 1ns/1ps
module tdm_frame_aligner_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_ref;
  logic [1:0] mode_sel;
  logic [1:0] rate_sel;
  logic [6:0] slot_idx;
  logic [2:0] bit_idx;
  logic       frame_pulse, locked, sync_lost;

  always #4 clk = ~clk;   // 125 MHz

  tdm_frame_aligner u_tdm_frame_aligner (
    .clk(clk), .rst_n(rst_n), .frame_ref(frame_ref), .mode_sel(mode_sel),
    .rate_sel(rate_sel), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .frame_pulse(frame_pulse), .locked(locked), .sync_lost(sync_lost)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  int m_pos, m_rate, m_mode, m_miss, m_good;
  bit m_locked, m_lost;
  // reference generator
  int gen_cnt, gen_len, drop_cnt;
  bit ref_en, last_ref;
  int prev_pos;

  function automatic int flen(input int r);
    return (r == 0) ? 256 : ((r == 1) ? 512 : 1024);
  endfunction

  function automatic int mdec(input logic [1:0] s);
    return (s >= 2) ? 2 : int'(s);
  endfunction

  function automatic int cur_pos();
    return int'({slot_idx, bit_idx});
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit r);
    int L, np;
    bit bnd, mst, realign;
    L = flen(m_rate);
    bnd = (m_pos == 0);
    mst = (m_mode == 2);
    realign = r && !mst && m_lost && (m_pos != 0);
    if (!realign)             np = (m_pos + 1) % L;
    else if (m_mode == 0)     np = 1;
    else if (m_pos < L / 2)   np = m_pos;
    else                      np = (m_pos + 2) % L;
    if (mst) begin
      m_lost = 0; m_locked = 0; m_miss = 0; m_good = 0;
    end else if (bnd) begin
      if (r) begin
        m_lost = 0; m_miss = 0;
        if (m_good < 4) m_good++;
        if (m_good >= 4) m_locked = 1;
      end else begin
        m_good = 0;
        if (m_miss < 2) m_miss++;
        if (m_miss >= 2) begin m_lost = 1; m_locked = 0; end
      end
    end else if (realign && m_mode == 0) begin
      m_lost = 0; m_miss = 0; m_good = 0;
    end
    if (bnd) begin
      m_rate = int'(rate_sel);
      m_mode = mdec(mode_sel);
    end
    m_pos = np;
  endtask

  task automatic tick();
    @(negedge clk);
    prev_pos = cur_pos();
    chk("R1", "position", cur_pos(), m_pos);
    chk("R1", "frame_pulse", int'(frame_pulse), int'(m_pos == 0));
    chk("R4", "sync_lost", int'(sync_lost), int'(m_lost));
    chk("R5", "locked", int'(locked), int'(m_locked));
    frame_ref = 1'b0;
    last_ref  = 1'b0;
    if (ref_en && gen_cnt == 0) begin
      if (drop_cnt > 0) drop_cnt--;
      else begin frame_ref = 1'b1; last_ref = 1'b1; end
    end
    @(posedge clk);
    model_step(frame_ref);
    gen_cnt = (gen_cnt == 0) ? gen_len - 1 : gen_cnt - 1;
  endtask

  task automatic wait_ref();
    int guard = 0;
    do begin tick(); guard++; end while (!last_ref && guard < 4000);
    #2;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(8 * 195000);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; frame_ref = 1'b0; mode_sel = 2'd0; rate_sel = 2'd0;
    ref_en = 0; drop_cnt = 0; gen_len = 256; gen_cnt = 37; last_ref = 0;
    m_pos = 0; m_rate = 2; m_mode = 0; m_miss = 0; m_good = 0;
    m_locked = 0; m_lost = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    // R10 reset state
    chk("R10", "reset position", cur_pos(), 0);
    chk("R10", "reset frame_pulse", int'(frame_pulse), 1);
    chk("R10", "reset sync_lost", int'(sync_lost), 1);
    chk("R10", "reset locked", int'(locked), 0);
    ref_en = 1;

    // R6 jump alignment to a reference at position 37
    wait_ref();
    chk("R6", "snap position", cur_pos(), 1);
    chk("R6", "snap clears sync_lost", int'(sync_lost), 0);

    // R5 lock after four coinciding frames
    repeat (3 * 256) tick(); #2;
    chk("R5", "not locked after 3 frames", int'(locked), 0);
    repeat (256) tick(); #2;
    chk("R5", "locked after 4 frames", int'(locked), 1);

    // R4 single missing edge tolerated
    wait_ref(); drop_cnt = 1;
    repeat (2 * 256 + 4) tick(); #2;
    chk("R4", "single miss keeps sync", int'(sync_lost), 0);
    chk("R5", "single miss keeps lock", int'(locked), 1);

    // R4 two missing edges
    wait_ref(); drop_cnt = 2;
    repeat (512) tick(); #2;
    chk("R4", "two misses lose sync", int'(sync_lost), 1);
    chk("R5", "lock dropped", int'(locked), 0);
    repeat (256) tick(); #2;
    chk("R4", "coinciding edge clears", int'(sync_lost), 0);

    // walk mode
    mode_sel = 2'd1;
    repeat (300) tick();
    wait_ref();
    gen_cnt = gen_cnt + 5;          // reference now 5 clocks late
    wait_ref();
    chk("R8", "misplaced edge ignored", cur_pos(), 6);
    wait_ref();
    chk("R7", "walk retard holds", cur_pos(), 5);
    chk("R7", "still out of sync", int'(sync_lost), 1);
    repeat (5) wait_ref();
    chk("R7", "walk converged", int'(sync_lost), 0);
    chk("R7", "walk converged position", cur_pos(), 1);

    gen_cnt = 252;                  // reference now 3 clocks early
    repeat (3) wait_ref();
    chk("R7", "walk advance by two", cur_pos(), 255);
    wait_ref();
    chk("R7", "advance across wrap", cur_pos(), 0);
    repeat (2) wait_ref();
    chk("R7", "advance converged", int'(sync_lost), 0);

    // tie at half frame advances
    gen_cnt = 127;
    repeat (3) wait_ref();
    chk("R7", "half-frame tie advances", cur_pos(), 130);

    // R9 master mode
    mode_sel = 2'd2;
    repeat (600) tick();
    gen_cnt = 77;
    wait_ref();
    chk("R9", "master ignores reference", cur_pos(), (prev_pos + 1) % 256);
    chk("R9", "master sync_lost low", int'(sync_lost), 0);
    chk("R9", "master locked low", int'(locked), 0);

    // R3 / R2 rate changes in master mode
    begin
      int guard = 0;
      while (cur_pos() != 20 && guard < 2000) begin tick(); #2; guard++; end
    end
    rate_sel = 2'd1;
    repeat (235) tick(); #2;
    chk("R3", "old rate last slot", int'(slot_idx), 31);
    chk("R3", "old rate last bit", int'(bit_idx), 7);
    tick(); #2;
    chk("R3", "old rate wraps at 256", cur_pos(), 0);
    repeat (256) tick(); #2;
    chk("R2", "64-slot frame continues", int'(slot_idx), 32);
    repeat (255) tick(); #2;
    chk("R2", "64-slot last slot", int'(slot_idx), 63);
    tick(); #2;
    chk("R2", "64-slot wrap", cur_pos(), 0);
    rate_sel = 2'd2;
    repeat (1023) tick(); #2;
    chk("R2", "128-slot last slot", int'(slot_idx), 127);
    tick(); #2;
    chk("R2", "128-slot wrap", cur_pos(), 0);
    rate_sel = 2'd3;
    repeat (1023) tick(); #2;
    chk("R2", "code 3 last slot", int'(slot_idx), 127);
    rate_sel = 2'd0;
    repeat (1100) tick();

    // random phase jumps, drops and mode changes
    for (int it = 0; it < 30; it++) begin
      int act = int'($urandom_range(0, 3));
      mode_sel = 2'($urandom_range(0, 1));
      if (act == 0) gen_cnt = int'($urandom_range(0, 255));
      else if (act == 1) drop_cnt = int'($urandom_range(1, 2));
      else if (act == 2) gen_cnt = (gen_cnt + int'($urandom_range(1, 3))) % 256;
      repeat (int'($urandom_range(256, 1024))) tick();
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule